// File: doc/BRIEF.md
# LCD Display Timing Generator

This block produces the raster timing for a parallel RGB LCD panel: a pixel-clock enable, horizontal and vertical sync, data-enable, and the current pixel and line positions. Software sets the sync width, back porch, active size and front porch of each axis through a small write/read register port. Every timing field holds its count minus one. A programmable divider turns the source clock into the pixel rate. A select bit can bypass the divider so that every source clock cycle is a pixel.

A frame interrupt can be placed at one of four points in the frame, one of them the start of vertical sync. It has a pending flag that software clears by writing 1, a frame enable that lets the flag set, and a global enable that lets the flag reach the interrupt pin. Output runs only while the video enable is set. Clearing the video enable stops the raster at once. Clearing the frame enable lets the current frame finish, and it takes effect at the next vertical sync. Setting the frame enable again starts a new frame at the next pixel tick.

The block carries no pixel data, so there is no valid/ready stream at its edge. The register port and all timing outputs are plain level signals. A write lands on the rising clock edge at which `reg_wr` is high. A read is combinational from `reg_addr`.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset, `hsync_o` and `vsync_o` are high (inactive), `de_o` and `pix_ce` are low, `irq_o` is low, both position counters are 0 and every register reads 0.
- R2: With HTIM (address 1) holding sync-1 in [7:0], back-1 in [15:8] and front-1 in [23:16], and SIZE (address 3) holding active-1 in [10:0], each line shows hsync active for sync pixels, then back porch pixels, then active pixels, then front porch pixels. The line period is the sum of the four.
- R3: VTIM (address 2) uses the HTIM layout for lines, and SIZE [26:16] holds active lines minus one. Each frame shows vsync active for sync lines and has a period equal to the sum of the four vertical counts. Vsync starts at pixel 0 of line 0.
- R4: Data-enable is active only when both positions lie in their active region. At the first active pixel of a frame, the pixel counter equals hsync+hback and the line counter equals vsync+vback.
- R5: CTRL (address 0) has bit0 video enable, bit1 frame enable, bit2 divider select and [15:8] divide ratio minus one. With bit2 set, `pix_ce` pulses once every ratio source cycles, ratio 1 to 256, and all timing scales by that ratio.
- R6: With divider select clear, `pix_ce` is high on every cycle while video is enabled, whatever the divide field holds.
- R7: POL (address 4) bit0 inverts hsync, bit1 inverts vsync and bit2 inverts data-enable. Without inversion the syncs are active low and data-enable is active high.
- R8: Clearing the video enable makes the syncs and data-enable inactive at once, and makes `pix_ce` and both counters 0 within two cycles.
- R9: Clearing the frame enable while the raster runs lets the current frame complete. The raster then stops at pixel 0, line 0, with no further vsync.
- R10: IRQ (address 5) has bit0 global enable, bit1 frame enable and [5:4] trigger select: 0 is vsync start, 1 is vsync end, 2 is the first active line, 3 is the first front porch line. The pending flag sets at pixel 0 of the selected line.
- R11: PEND (address 6) bit0 reads the pending flag. Writing 1 clears it, and writing 0 leaves it unchanged.
- R12: `irq_o` is the pending flag gated by the global enable. With the frame enable clear, the pending flag never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| pix_ce | output | 1 | Pixel clock enable |
| hsync_o | output | 1 | Horizontal sync, polarity per POL |
| vsync_o | output | 1 | Vertical sync, polarity per POL |
| de_o | output | 1 | Data-enable, polarity per POL |
| h_cnt | output | 13 | Current pixel position in the line |
| v_cnt | output | 13 | Current line position in the frame |
| irq_o | output | 1 | Frame interrupt |

## Verification
The assertions check on every cycle:
- each axis counter steps by one or wraps to zero on a pixel advance;
- the divider never ticks on two cycles in a row when the ratio is above one;
- data-enable never overlaps a sync;
- vsync only starts at pixel 0;
- the raster stops only at the origin;
- the pending flag rises only after a trigger event, holds until a write of 1, and clears on that write.

Only the bench scenarios can show the following:
- the measured widths and periods in source cycles for each programmed timing, divide ratio and bypass;
- the position counters at the first active pixel;
- the inverted idle levels;
- the line on which each trigger select fires;
- the full frame that follows a cleared frame enable.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int PORCH_W = 8;
  localparam int ACT_W   = 11;
  localparam int DIV_W   = 8;
  localparam int CNT_W   = ACT_W + 2;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 32;

  typedef enum logic [ADDR_W-1:0] {
    R_CTRL = 3'd0,
    R_HTIM = 3'd1,
    R_VTIM = 3'd2,
    R_SIZE = 3'd3,
    R_POL  = 3'd4,
    R_IRQ  = 3'd5,
    R_PEND = 3'd6
  } reg_sel_e;

  typedef enum logic [1:0] {
    TRG_SYNC_START = 2'd0,
    TRG_SYNC_END   = 2'd1,
    TRG_ACT_START  = 2'd2,
    TRG_FP_START   = 2'd3
  } trig_e;

  typedef struct packed {
    logic [PORCH_W-1:0] sync_m1;
    logic [PORCH_W-1:0] back_m1;
    logic [PORCH_W-1:0] front_m1;
    logic [ACT_W-1:0]   act_m1;
  } axis_cfg_t;

  typedef struct packed {
    logic hs_inv;
    logic vs_inv;
    logic de_inv;
  } pol_t;
endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
  import lcdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              pend_set,
  output logic              video_on,
  output logic              frame_on,
  output logic              div_sel,
  output logic [DIV_W-1:0]  div_m1,
  output axis_cfg_t         h_cfg,
  output axis_cfg_t         v_cfg,
  output pol_t              pol,
  output logic              irq_glb,
  output logic              irq_frm,
  output trig_e             irq_sel,
  output logic              pend
);
  logic clr_hit;
  logic unused_wdata;

  assign clr_hit      = wr && (reg_sel_e'(addr) == R_PEND) && wdata[0];
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      video_on <= 1'b0;
      frame_on <= 1'b0;
      div_sel  <= 1'b0;
      div_m1   <= '0;
      h_cfg    <= '0;
      v_cfg    <= '0;
      pol      <= '0;
      irq_glb  <= 1'b0;
      irq_frm  <= 1'b0;
      irq_sel  <= TRG_SYNC_START;
    end else if (wr) begin
      case (reg_sel_e'(addr))
        R_CTRL: begin
          video_on <= wdata[0];
          frame_on <= wdata[1];
          div_sel  <= wdata[2];
          div_m1   <= wdata[8 +: DIV_W];
        end
        R_HTIM: begin
          h_cfg.sync_m1  <= wdata[0 +: PORCH_W];
          h_cfg.back_m1  <= wdata[8 +: PORCH_W];
          h_cfg.front_m1 <= wdata[16 +: PORCH_W];
        end
        R_VTIM: begin
          v_cfg.sync_m1  <= wdata[0 +: PORCH_W];
          v_cfg.back_m1  <= wdata[8 +: PORCH_W];
          v_cfg.front_m1 <= wdata[16 +: PORCH_W];
        end
        R_SIZE: begin
          h_cfg.act_m1 <= wdata[0 +: ACT_W];
          v_cfg.act_m1 <= wdata[16 +: ACT_W];
        end
        R_POL: begin
          pol.hs_inv <= wdata[0];
          pol.vs_inv <= wdata[1];
          pol.de_inv <= wdata[2];
        end
        R_IRQ: begin
          irq_glb <= wdata[0];
          irq_frm <= wdata[1];
          irq_sel <= trig_e'(wdata[5:4]);
        end
        default: ;
      endcase
    end
  end

  // Pending flag: a new event wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_set | (pend & ~clr_hit);
  end

  always_comb begin
    rdata = '0;
    case (reg_sel_e'(addr))
      R_CTRL: begin
        rdata[0]          = video_on;
        rdata[1]          = frame_on;
        rdata[2]          = div_sel;
        rdata[8 +: DIV_W] = div_m1;
      end
      R_HTIM: begin
        rdata[0 +: PORCH_W]  = h_cfg.sync_m1;
        rdata[8 +: PORCH_W]  = h_cfg.back_m1;
        rdata[16 +: PORCH_W] = h_cfg.front_m1;
      end
      R_VTIM: begin
        rdata[0 +: PORCH_W]  = v_cfg.sync_m1;
        rdata[8 +: PORCH_W]  = v_cfg.back_m1;
        rdata[16 +: PORCH_W] = v_cfg.front_m1;
      end
      R_SIZE: begin
        rdata[0 +: ACT_W]  = h_cfg.act_m1;
        rdata[16 +: ACT_W] = v_cfg.act_m1;
      end
      R_POL: begin
        rdata[0] = pol.hs_inv;
        rdata[1] = pol.vs_inv;
        rdata[2] = pol.de_inv;
      end
      R_IRQ: begin
        rdata[0]   = irq_glb;
        rdata[1]   = irq_frm;
        rdata[5:4] = irq_sel;
      end
      R_PEND:  rdata[0] = pend;
      default: ;
    endcase
  end

  // R11: a write of 1 clears the flag when no event collides
  a_r11_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !pend_set) |=> !pend);
  // R11: without a clearing write the flag holds
  a_r11_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr_hit) |=> pend);
endmodule

// File: rtl/lcdt_pixdiv.sv
module lcdt_pixdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             use_div,
  input  logic [DIV_W-1:0] div_m1,
  output logic             tick
);
  localparam logic [DIV_W-1:0] STEP = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q >= div_m1);
  assign tick   = run & (~use_div | at_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (!run || !use_div || at_end) cnt_q <= '0;
    else                                 cnt_q <= cnt_q + STEP;
  end

  // R5: a ratio above one never ticks on two consecutive cycles
  a_r5_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && use_div && (div_m1 != '0) && $stable(div_m1) && $past(run) && $past(use_div))
      |=> !tick);
endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis
  import lcdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  axis_cfg_t        cfg,
  input  trig_e            mark_sel,
  output logic [CNT_W-1:0] cnt,
  output logic             in_sync,
  output logic             in_act,
  output logic             at_last,
  output logic             at_mark
);
  localparam logic [CNT_W-1:0] STEP = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] pos_bp, pos_act, pos_fp, pos_last, mark_pos;

  assign pos_bp   = CNT_W'(cfg.sync_m1) + STEP;
  assign pos_act  = pos_bp + CNT_W'(cfg.back_m1) + STEP;
  assign pos_fp   = pos_act + CNT_W'(cfg.act_m1) + STEP;
  assign pos_last = pos_fp + CNT_W'(cfg.front_m1);

  assign in_sync = (cnt < pos_bp);
  assign in_act  = (cnt >= pos_act) && (cnt < pos_fp);
  assign at_last = (cnt >= pos_last);

  always_comb begin
    case (mark_sel)
      TRG_SYNC_START: mark_pos = '0;
      TRG_SYNC_END:   mark_pos = pos_bp;
      TRG_ACT_START:  mark_pos = pos_act;
      default:        mark_pos = pos_fp;
    endcase
  end
  assign at_mark = (cnt == mark_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (adv) cnt <= at_last ? '0 : cnt + STEP;
  end

  // R2: wrap to zero after the last position
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && at_last && !clr) |=> (cnt == '0));
  // R2: otherwise step by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !at_last && !clr) |=> (cnt == $past(cnt) + STEP));
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pix_ce,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [CNT_W-1:0]  h_cnt,
  output logic [CNT_W-1:0]  v_cnt,
  output logic              irq_o
);
  logic             video_on, frame_on, div_sel, irq_glb, irq_frm, pend;
  logic [DIV_W-1:0] div_m1;
  axis_cfg_t        h_cfg, v_cfg;
  pol_t             pol;
  trig_e            irq_sel;

  logic tick, frame_live, running;
  logic h_adv, v_adv, frame_end, evt;
  logic h_sync, h_act, h_last, h_mark;
  logic v_sync, v_act, v_last, v_mark;
  logic hs_act, vs_act, de_act;

  lcdt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .pend_set(evt), .video_on(video_on), .frame_on(frame_on),
    .div_sel(div_sel), .div_m1(div_m1), .h_cfg(h_cfg), .v_cfg(v_cfg), .pol(pol),
    .irq_glb(irq_glb), .irq_frm(irq_frm), .irq_sel(irq_sel), .pend(pend)
  );

  lcdt_pixdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(video_on), .use_div(div_sel),
    .div_m1(div_m1), .tick(tick)
  );

  assign running   = video_on & frame_live;
  assign h_adv     = running & tick;
  assign v_adv     = h_adv & h_last;
  assign frame_end = v_adv & v_last;

  lcdt_axis u_hax (
    .clk(clk), .rst_n(rst_n), .clr(~video_on), .adv(h_adv), .cfg(h_cfg),
    .mark_sel(TRG_SYNC_START), .cnt(h_cnt), .in_sync(h_sync), .in_act(h_act),
    .at_last(h_last), .at_mark(h_mark)
  );

  lcdt_axis u_vax (
    .clk(clk), .rst_n(rst_n), .clr(~video_on), .adv(v_adv), .cfg(v_cfg),
    .mark_sel(irq_sel), .cnt(v_cnt), .in_sync(v_sync), .in_act(v_act),
    .at_last(v_last), .at_mark(v_mark)
  );

  // Frame enable is sampled while idle, or at the close of each frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    frame_live <= 1'b0;
    else if (!video_on)            frame_live <= 1'b0;
    else if (!frame_live && tick)  frame_live <= frame_on;
    else if (frame_end)            frame_live <= frame_on;
  end

  assign hs_act = running & h_sync;
  assign vs_act = running & v_sync;
  assign de_act = running & h_act & v_act;

  assign hsync_o = hs_act ^ ~pol.hs_inv;
  assign vsync_o = vs_act ^ ~pol.vs_inv;
  assign de_o    = de_act ^ pol.de_inv;
  assign pix_ce  = tick;

  assign evt   = h_adv & h_mark & v_mark & irq_frm;
  assign irq_o = pend & irq_glb;

  // R8: with video disabled the counters sit at zero next cycle
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !video_on |=> (h_cnt == '0 && v_cnt == '0));
  // R9: the raster only stops at the origin
  a_r9_stop_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (video_on && $past(video_on) && $fell(frame_live)) |-> (h_cnt == '0 && v_cnt == '0));
  // R3: vsync begins at pixel 0
  a_r3_vs_at_pixel0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vs_act) |-> (h_cnt == '0));
  // R4: data-enable never overlaps a sync interval
  a_r4_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
    de_act |-> (!hs_act && !vs_act));
  // R10: pending rises only after a trigger event
  a_r10_pend_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(evt));
endmodule

// File: tb/tb_lcd_timing_gen.sv
`timescale 1ns/1ps
module tb_lcd_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pix_ce, hsync_o, vsync_o, de_o, irq_o;
  logic [12:0] h_cnt, v_cnt;

  always #2.5 clk = ~clk;

  lcd_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_ce(pix_ce),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .h_cnt(h_cnt),
    .v_cnt(v_cnt), .irq_o(irq_o)
  );

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;
  bit  pol_hs = 0, pol_vs = 0, pol_de = 0;

  typedef struct {
    int    hs_w, line, de_w, de_lines, de_tot, vs_w, frame, ce, de_h, de_v;
    string div_tag;
  } frame_rec_t;

  frame_rec_t exp_q[$];
  bit mon_arm = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit hs_a(); return ~hsync_o ^ pol_hs; endfunction
  function automatic bit vs_a(); return ~vsync_o ^ pol_vs; endfunction
  function automatic bit de_a(); return de_o ^ pol_de; endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] tim(input int s, input int b, input int f);
    return 32'((s - 1) | ((b - 1) << 8) | ((f - 1) << 16));
  endfunction

  // Monitor: measures one frame and compares it with the queued expectation.
  task automatic measure(output frame_rec_t m);
    bit pv, ph, pd;
    int hs_rises, hs1;
    m = '{default: 0, div_tag: ""};
    hs_rises = 0; hs1 = 0;
    do begin pv = vs_a(); @(negedge clk); end while (!(vs_a() && !pv));
    ph = 0; pd = 0;
    forever begin
      if (m.frame > 0 && vs_a() && !pv) break;
      m.frame++;
      if (vs_a()) m.vs_w++;
      if (pix_ce) m.ce++;
      if (hs_a() && !ph) begin
        hs_rises++;
        if (hs_rises == 1) hs1 = m.frame;
        if (hs_rises == 2) m.line = m.frame - hs1;
      end
      if (hs_rises == 1 && hs_a()) m.hs_w++;
      if (de_a() && !pd) begin
        m.de_lines++;
        if (m.de_lines == 1) begin m.de_h = int'(h_cnt); m.de_v = int'(v_cnt); end
      end
      if (de_a()) begin
        m.de_tot++;
        if (m.de_lines == 1) m.de_w++;
      end
      pv = vs_a(); ph = hs_a(); pd = de_a();
      @(negedge clk);
    end
  endtask

  initial begin
    frame_rec_t m, e;
    forever begin
      wait (mon_arm);
      measure(m);
      e = exp_q.pop_front();
      chk(m.hs_w == e.hs_w, "R2 hsync width", m.hs_w, e.hs_w);
      chk(m.line == e.line, "R2 line period", m.line, e.line);
      chk(m.de_w == e.de_w, "R2 active run", m.de_w, e.de_w);
      chk(m.de_h == e.de_h, "R4 first active pixel", m.de_h, e.de_h);
      chk(m.de_v == e.de_v, "R4 first active line", m.de_v, e.de_v);
      chk(m.de_tot == e.de_tot, "R4 active cycles", m.de_tot, e.de_tot);
      chk(m.de_lines == e.de_lines, "R3 active lines", m.de_lines, e.de_lines);
      chk(m.vs_w == e.vs_w, "R3 vsync width", m.vs_w, e.vs_w);
      chk(m.frame == e.frame, "R3 frame period", m.frame, e.frame);
      chk(m.ce == e.ce, {e.div_tag, " pixel ticks per frame"}, m.ce, e.ce);
      mon_arm = 0;
    end
  end

  // Driver: program one timing set, queue expectations, run one frame.
  task automatic scenario(input int hs, input int hb, input int ha, input int hf,
                          input int vs, input int vb, input int va, input int vf,
                          input bit dsel, input int ratio, input bit [2:0] pol);
    frame_rec_t e;
    int d, ht, vt;
    d  = dsel ? ratio : 1;
    ht = hs + hb + ha + hf;
    vt = vs + vb + va + vf;
    wr(3'd1, tim(hs, hb, hf));
    wr(3'd2, tim(vs, vb, vf));
    wr(3'd3, 32'((ha - 1) | ((va - 1) << 16)));
    wr(3'd4, {29'd0, pol});
    pol_hs = pol[0]; pol_vs = pol[1]; pol_de = pol[2];
    e.hs_w = hs * d; e.line = ht * d; e.de_w = ha * d; e.de_lines = va;
    e.de_tot = va * ha * d; e.vs_w = vs * ht * d; e.frame = vt * ht * d;
    e.ce = vt * ht; e.de_h = hs + hb; e.de_v = vs + vb;
    e.div_tag = dsel ? "R5" : "R6";
    exp_q.push_back(e);
    mon_arm = 1;
    wr(3'd0, 32'(3 | (int'(dsel) << 2) | ((ratio - 1) << 8)));
    wait (!mon_arm);
    wr(3'd0, 32'd0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    int cnt_de, cnt_vs, seen;
    bit pd, pv, irq_seen;
    int pts[4];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(hsync_o == 1'b1, "R1 hsync idle", hsync_o, 1);
    chk(vsync_o == 1'b1, "R1 vsync idle", vsync_o, 1);
    chk(de_o == 1'b0, "R1 de idle", de_o, 0);
    chk(pix_ce == 1'b0, "R1 pix_ce idle", pix_ce, 0);
    chk(irq_o == 1'b0, "R1 irq idle", irq_o, 0);
    chk(h_cnt == 0 && v_cnt == 0, "R1 counters", h_cnt + v_cnt, 0);
    rd(3'd0, rv); chk(rv == 0, "R1 ctrl reads 0", rv, 0);
    rd(3'd6, rv); chk(rv == 0, "R1 pend reads 0", rv, 0);

    // Main timing under several patterns
    scenario(2, 3, 4, 1, 1, 2, 3, 1, 1'b0, 1, 3'b000);
    scenario(2, 3, 4, 1, 1, 2, 3, 1, 1'b1, 3, 3'b000);
    wr(3'd4, 32'd7);
    @(negedge clk);
    // R7 inverted idle levels
    chk(hsync_o == 1'b0, "R7 inverted hsync idle", hsync_o, 0);
    chk(vsync_o == 1'b0, "R7 inverted vsync idle", vsync_o, 0);
    chk(de_o == 1'b1, "R7 inverted de idle", de_o, 1);
    scenario(1, 1, 6, 2, 2, 1, 4, 2, 1'b0, 6, 3'b111);
    scenario(1, 1, 1, 1, 1, 1, 1, 1, 1'b1, 256, 3'b000);

    // R8: video off stops at once
    scenario(2, 3, 4, 1, 1, 2, 3, 1, 1'b0, 1, 3'b000);
    wr(3'd0, 32'd3);
    seen = 0;
    while (!de_a() && seen < 200) begin @(negedge clk); seen++; end
    wr(3'd0, 32'd0);
    chk(hsync_o == 1 && vsync_o == 1 && de_o == 0, "R8 outputs inactive",
        {hsync_o, vsync_o, de_o}, 3'b110);
    @(negedge clk);
    chk(h_cnt == 0 && v_cnt == 0, "R8 counters cleared", h_cnt + v_cnt, 0);
    chk(pix_ce == 0, "R8 pix_ce stopped", pix_ce, 0);

    // R9: frame enable clear completes the frame
    wr(3'd0, 32'd3);
    pv = vs_a();
    seen = 0;
    while (!(vs_a() && !pv) && seen < 300) begin pv = vs_a(); @(negedge clk); seen++; end
    wr(3'd0, 32'd1);
    cnt_de = 0; cnt_vs = 0; pd = de_a(); pv = vs_a();
    for (int i = 0; i < 210; i++) begin
      @(negedge clk);
      if (de_a() && !pd) cnt_de++;
      if (vs_a() && !pv) cnt_vs++;
      pd = de_a(); pv = vs_a();
    end
    chk(cnt_de == 3, "R9 remaining active lines", cnt_de, 3);
    chk(cnt_vs == 0, "R9 no further vsync", cnt_vs, 0);
    chk(h_cnt == 0 && v_cnt == 0, "R9 parked at origin", h_cnt + v_cnt, 0);

    // R10/R11: trigger select and write-1-to-clear
    pts[0] = 0; pts[1] = 1; pts[2] = 3; pts[3] = 6;
    wr(3'd0, 32'd3);
    for (int s = 0; s < 4; s++) begin
      wr(3'd5, 32'(3 | (s << 4)));
      wr(3'd6, 32'd1);
      seen = 0;
      while (!irq_o && seen < 300) begin @(negedge clk); seen++; end
      chk(irq_o == 1, "R10 interrupt raised", irq_o, 1);
      chk(int'(v_cnt) == pts[s], "R10 trigger line", v_cnt, pts[s]);
      chk(h_cnt == 1, "R10 trigger at pixel 0", h_cnt, 1);
      if (s == 0) begin
        wr(3'd6, 32'd0);
        chk(irq_o == 1, "R11 write 0 keeps pending", irq_o, 1);
      end
      wr(3'd6, 32'd1);
      chk(irq_o == 0, "R11 write 1 clears pending", irq_o, 0);
    end

    // R12: global enable gates the pin, frame enable gates the flag
    wr(3'd5, 32'd2);
    wr(3'd6, 32'd1);
    irq_seen = 0;
    for (int i = 0; i < 150; i++) begin @(negedge clk); if (irq_o) irq_seen = 1; end
    chk(irq_seen == 0, "R12 pin masked by global enable", irq_seen, 0);
    rd(3'd6, rv); chk(rv[0] == 1, "R12 flag still set while masked", rv[0], 1);
    wr(3'd5, 32'd1);
    wr(3'd6, 32'd1);
    irq_seen = 0;
    for (int i = 0; i < 150; i++) begin @(negedge clk); if (irq_o) irq_seen = 1; end
    rd(3'd6, rv); chk(rv[0] == 0, "R12 flag blocked by frame enable", rv[0], 0);
    chk(irq_seen == 0, "R12 no interrupt without frame enable", irq_seen, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule